// File: doc/BRIEF.md
# Reaction Timer with Millisecond Display

This block measures how quickly an operator responds to a light. Raising the start key arms the timer. The timer then waits for an exact number of clock cycles, set by an 8-bit delay input, and turns on an indicator LED. While the LED is on, a four-digit decimal count goes up by one every millisecond and appears on four seven-segment outputs. Pressing the stop key turns the LED off and holds the count on the display. The held count is the reaction time in milliseconds.

The start key also works as the block's asynchronous active-low reset. Holding it at 0 keeps everything cleared. Its rising edge is released into the clock domain through a two-flop synchronizer. The stop key is synchronized and edge-detected. The number of clock cycles in one millisecond is a parameter: 50,000 for a 50 MHz clock, and a small value in simulation.

Top module: `rxn_timer`

## Requirements
- R1: While `start_key` is 0, the LED vector reads 0 and the display shows 0000. Stop presses in this time have no effect.
- R2: If `start_key` rises between clock edges and N is the value on `delay_sw`, `led[0]` goes high after the (3+N)-th rising clock edge that follows. With N = 0 this is the third edge.
- R3: With `led[0]` high, the display value is n after n×MS_CYC edges, counted from the edge that lit the LED.
- R4: The count is held as four BCD digits. `seg_d0` shows the least significant digit and `seg_d3` the most significant. Decimal carries ripple upward, so 9 becomes 10 and 99 becomes 100.
- R5: The count saturates at 9999. It never wraps.
- R6: A stop press is a 0-to-1 change on `stop_key`. A press while `led[0]` is high clears `led[0]` after the third clock edge following the press. The display keeps the count reached after the second edge, and it then stays unchanged until `start_key` falls.
- R7: A stop press made before the LED lights is ignored. Holding the key down does not stop the count later. The count stops only after the key is released and pressed again.
- R8: The segment outputs are active-low, with bit 0 = segment a up to bit 6 = segment g. The lit segments for each digit are: 0 abcdef, 1 bc, 2 abdeg, 3 abcdg, 4 bcfg, 5 acdfg, 6 acdefg, 7 abc, 8 all seven, 9 abcdfg.
- R9: `led[1]` is always 0.
- R10: Dropping `start_key` to 0 clears the LED and the display at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| start_key | input | 1 | Arms the timer when 1; asynchronous clear when 0 |
| stop_key | input | 1 | Stop button, asynchronous, active high |
| delay_sw | input | 8 | Number of cycles to wait before lighting the LED |
| seg_d0 | output | 7 | Units digit, active-low segments |
| seg_d1 | output | 7 | Tens digit, active-low segments |
| seg_d2 | output | 7 | Hundreds digit, active-low segments |
| seg_d3 | output | 7 | Thousands digit, active-low segments |
| led | output | 2 | Bit 0 is the reaction indicator; bit 1 is held low |

## Verification
The bench checks the cycle on which the LED lights for a zero delay and for a nonzero delay. A delay counter that is off by one, or that ignores a match on zero, would light the LED one edge early or late. It then runs the count through the 9-to-10, 99-to-100 and 999-to-1000 carries and past 9999. A digit that wraps or does not carry, or a counter that rolls over to 0000, would show the wrong segments. It also presses stop during the wait and keeps the key held through the lit phase. A design that reacts to the level of the key instead of a fresh edge, or that remembers the early press, would stop the count too soon. Finally it checks that dropping the start key clears the display without a clock edge.

// File: rtl/rxn_pkg.sv
`timescale 1ns/1ps
package rxn_pkg;

  localparam int NDIG = 4;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } state_t;

  // active-low seven-segment code, bit 0 = a ... bit 6 = g
  function automatic logic [6:0] seg7_low(input logic [3:0] d);
    logic [6:0] on;
    case (d)
      4'd0:    on = 7'b0111111;
      4'd1:    on = 7'b0000110;
      4'd2:    on = 7'b1011011;
      4'd3:    on = 7'b1001111;
      4'd4:    on = 7'b1100110;
      4'd5:    on = 7'b1101101;
      4'd6:    on = 7'b1111101;
      4'd7:    on = 7'b0000111;
      4'd8:    on = 7'b1111111;
      4'd9:    on = 7'b1101111;
      default: on = 7'b0000000;
    endcase
    return ~on;
  endfunction

endpackage

// File: rtl/rxn_sync.sv
`timescale 1ns/1ps
module rxn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q = sr_q[STAGES-1];

endmodule

// File: rtl/rxn_ctrl.sv
`timescale 1ns/1ps
module rxn_ctrl
  import rxn_pkg::*;
#(
  parameter int DLY_W  = 8,
  parameter int MS_CYC = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] delay_sw,
  input  logic             stop_s,
  output logic             led_on,
  output logic             tick,
  output state_t           state,
  output logic [DLY_W-1:0] dly_cnt
);

  localparam int PRE_W = (MS_CYC > 1) ? $clog2(MS_CYC) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(MS_CYC - 1);

  state_t             state_q, state_d;
  logic [DLY_W-1:0]   dly_q, dly_d;
  logic [PRE_W-1:0]   pre_q, pre_d;
  logic               dly_en, pre_en;
  logic               stop_q;
  logic               stop_rise;

  assign stop_rise = stop_s & ~stop_q;

  always_comb begin
    state_d = state_q;
    dly_en  = 1'b0;
    dly_d   = dly_q + 1'b1;
    pre_en  = 1'b0;
    pre_d   = pre_q;
    tick    = 1'b0;
    case (state_q)
      ST_WAIT: begin
        if (dly_q == delay_sw) begin
          state_d = ST_RUN;
          pre_en  = 1'b1;
          pre_d   = '0;
        end else begin
          dly_en = 1'b1;
        end
      end
      ST_RUN: begin
        if (stop_rise) begin
          state_d = ST_HALT;
        end else begin
          pre_en = 1'b1;
          if (pre_q == PRE_LAST) begin
            pre_d = '0;
            tick  = 1'b1;
          end else begin
            pre_d = pre_q + 1'b1;
          end
        end
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      dly_q   <= '0;
      pre_q   <= '0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stop_q  <= stop_s;
      if (dly_en) dly_q <= dly_d;
      if (pre_en) pre_q <= pre_d;
    end
  end

  assign led_on  = (state_q == ST_RUN);
  assign state   = state_q;
  assign dly_cnt = dly_q;

endmodule

// File: rtl/rxn_bcd_cnt.sv
`timescale 1ns/1ps
module rxn_bcd_cnt #(
  parameter int NDIG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  output logic [NDIG*4-1:0] bcd
);

  logic [NDIG-1:0] is9;
  logic [NDIG:0]   carry;
  logic            full;

  assign carry[0] = inc;
  assign full     = &is9;

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    logic [3:0] dig_q, dig_d;
    logic       dig_en;

    assign is9[i]     = (dig_q == 4'd9);
    assign carry[i+1] = carry[i] & is9[i];
    assign dig_en     = carry[i] & ~full;

    always_comb begin
      dig_d = is9[i] ? 4'd0 : dig_q + 4'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dig_q <= 4'd0;
      else if (dig_en) dig_q <= dig_d;
    end

    assign bcd[i*4 +: 4] = dig_q;
  end

endmodule

// File: rtl/rxn_seg7.sv
`timescale 1ns/1ps
module rxn_seg7
  import rxn_pkg::*;
(
  input  logic [3:0] digit,
  output logic [6:0] seg_n
);

  always_comb begin
    seg_n = seg7_low(digit);
  end

endmodule

// File: rtl/rxn_timer.sv
`timescale 1ns/1ps
module rxn_timer
  import rxn_pkg::*;
#(
  parameter int DLY_W  = 8,
  parameter int MS_CYC = 50000
) (
  input  logic             clk,
  input  logic             start_key,
  input  logic             stop_key,
  input  logic [DLY_W-1:0] delay_sw,
  output logic [6:0]       seg_d0,
  output logic [6:0]       seg_d1,
  output logic [6:0]       seg_d2,
  output logic [6:0]       seg_d3,
  output logic [1:0]       led
);

  logic               rst_i;
  logic               stop_s;
  logic               led_on;
  logic               tick_w;
  state_t             state_w;
  logic [DLY_W-1:0]   dly_w;
  logic [NDIG*4-1:0]  bcd_w;
  logic [6:0]         seg_arr [NDIG];

  // start key: asynchronous clear, synchronous release
  rxn_sync #(.STAGES(2)) u_rst_sync (
    .clk  (clk),
    .rst_n(start_key),
    .d    (1'b1),
    .q    (rst_i)
  );

  rxn_sync #(.STAGES(2)) u_stop_sync (
    .clk  (clk),
    .rst_n(rst_i),
    .d    (stop_key),
    .q    (stop_s)
  );

  rxn_ctrl #(.DLY_W(DLY_W), .MS_CYC(MS_CYC)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_i),
    .delay_sw(delay_sw),
    .stop_s  (stop_s),
    .led_on  (led_on),
    .tick    (tick_w),
    .state   (state_w),
    .dly_cnt (dly_w)
  );

  rxn_bcd_cnt #(.NDIG(NDIG)) u_bcd (
    .clk  (clk),
    .rst_n(rst_i),
    .inc  (tick_w),
    .bcd  (bcd_w)
  );

  for (genvar g = 0; g < NDIG; g++) begin : g_seg
    rxn_seg7 u_seg (
      .digit(bcd_w[g*4 +: 4]),
      .seg_n(seg_arr[g])
    );
  end

  assign seg_d0 = seg_arr[0];
  assign seg_d1 = seg_arr[1];
  assign seg_d2 = seg_arr[2];
  assign seg_d3 = seg_arr[3];
  assign led    = {1'b0, led_on};

endmodule

// File: rtl/rxn_timer_chk.sv
`timescale 1ns/1ps
module rxn_timer_chk
  import rxn_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       led,
  input logic [DLY_W-1:0] delay_sw,
  input logic [DLY_W-1:0] dly_cnt,
  input logic             tick,
  input state_t           state,
  input logic [15:0]      bcd
);

  function automatic logic all_bcd(input logic [15:0] v);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) &&
           (v[11:8] <= 4'd9) && (v[15:12] <= 4'd9);
  endfunction

  // R2: the LED lights only when the delay count has met the switch value
  a_r2_led_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(led[0]) |-> ($past(dly_cnt) == $past(delay_sw)));

  // R3: the display moves only on a millisecond tick
  a_r3_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(bcd));

  // R4: every digit stays in decimal range
  a_r4_digits_bcd: assert property (@(posedge clk) disable iff (!rst_n)
    all_bcd(bcd));

  // R5: the count sticks at 9999
  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (bcd == 16'h9999) |=> (bcd == 16'h9999));

  // R6: once stopped, the LED is dark and the count is frozen
  a_r6_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |=> ((state == ST_HALT) && $stable(bcd) && !led[0]));

  // R9: upper LED bit never lights
  a_r9_led1_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !led[1]);

endmodule

bind rxn_timer rxn_timer_chk #(.DLY_W(DLY_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_i),
  .led     (led),
  .delay_sw(delay_sw),
  .dly_cnt (dly_w),
  .tick    (tick_w),
  .state   (state_w),
  .bcd     (bcd_w)
);

// File: tb/rxn_timer_tb_top.sv
`timescale 1ns/1ps
module rxn_timer_tb_top;

  localparam int CLK_PERIOD = 20;
  localparam int MS         = 4;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    int    at;
    logic  ledx;
    int    cnt;
    string tag;
  } exp_t;

  logic       clk;
  logic       start_key;
  logic       stop_key;
  logic [7:0] delay_sw;
  logic [6:0] seg_d0, seg_d1, seg_d2, seg_d3;
  logic [1:0] led;

  int   cyc;
  int   checks;
  int   errors;
  exp_t sb_q[$];

  rxn_timer #(.DLY_W(8), .MS_CYC(MS)) dut_i (
    .clk      (clk),
    .start_key(start_key),
    .stop_key (stop_key),
    .delay_sw (delay_sw),
    .seg_d0   (seg_d0),
    .seg_d1   (seg_d1),
    .seg_d2   (seg_d2),
    .seg_d3   (seg_d3),
    .led      (led)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // R8 segment table, active-low, bit0 = a .. bit6 = g
  function automatic logic [6:0] exp_seg(input int d);
    case (d)
      0: return 7'b1000000;
      1: return 7'b1111001;
      2: return 7'b0100100;
      3: return 7'b0110000;
      4: return 7'b0011001;
      5: return 7'b0010010;
      6: return 7'b0000010;
      7: return 7'b1111000;
      8: return 7'b0000000;
      default: return 7'b0010000;
    endcase
  endfunction

  // expected count n*MS edges after the lighting edge, saturating (R3, R5)
  function automatic int ms_at(input int e, input int lit);
    int n;
    n = (e - lit) / MS;
    return (n > 9999) ? 9999 : n;
  endfunction

  // driver side of the scoreboard: keep the queue ordered by sample cycle
  task automatic push(input int at, input logic ledx, input int cnt, input string tag);
    exp_t it;
    int   pos;
    it.at = at; it.ledx = ledx; it.cnt = cnt; it.tag = tag;
    pos = sb_q.size();
    for (int i = 0; i < sb_q.size(); i++) begin
      if (sb_q[i].at > at) begin
        pos = i;
        break;
      end
    end
    sb_q.insert(pos, it);
  endtask

  task automatic at_neg(input int c);
    @(negedge clk);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: compare at the falling edge after the expected edge
  initial begin
    exp_t        it;
    logic [27:0] want_seg;
    logic [27:0] got_seg;
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
        it = sb_q.pop_front();
        checks++;
        want_seg = {exp_seg((it.cnt / 1000) % 10), exp_seg((it.cnt / 100) % 10),
                    exp_seg((it.cnt / 10) % 10), exp_seg(it.cnt % 10)};
        got_seg  = {seg_d3, seg_d2, seg_d1, seg_d0};
        if (it.at != cyc) begin
          errors++;
          $display("FAIL %s: sample missed, at cycle %0d expected cycle %0d", it.tag, cyc, it.at);
        end else if (led !== {1'b0, it.ledx} || got_seg !== want_seg) begin
          errors++;
          $display("FAIL %s (R9 led1/R8 seg) cycle %0d: led=%b seg=%h, expected led=%b seg=%h (count %0d)",
                   it.tag, cyc, led, got_seg, {1'b0, it.ledx}, want_seg, it.cnt);
        end
      end
    end
  end

  // watchdog
  initial begin
    wait (cyc >= WATCHDOG);
    errors++;
    $display("FAIL watchdog: cycle %0d reached, expected end before %0d", cyc, WATCHDOG);
    summary();
  end

  initial begin
    int lit;
    checks    = 0;
    errors    = 0;
    start_key = 1'b0;
    stop_key  = 1'b0;
    delay_sw  = 8'd0;

    // R1: held clear while start is low, stop presses have no effect
    push(3, 1'b0, 0, "R1 idle");
    push(6, 1'b0, 0, "R1 stop while idle");
    at_neg(2); stop_key = 1'b1;
    at_neg(4); stop_key = 1'b0;

    // R2 with zero delay, R3 millisecond steps, R6 stop
    lit = 11;
    push(10, 1'b0, 0, "R2 sw=0 still dark");
    push(11, 1'b1, 0, "R2 sw=0 lit on third edge");
    push(14, 1'b1, 0, "R3 before first ms");
    push(15, 1'b1, 1, "R3 first ms");
    push(19, 1'b1, 2, "R3 second ms");
    push(23, 1'b1, ms_at(23, lit), "R6 before stop acts");
    push(24, 1'b0, ms_at(23, lit), "R6 LED off after stop");
    push(40, 1'b0, ms_at(23, lit), "R6 count frozen");
    push(43, 1'b0, 0, "R10 clear on start low");
    at_neg(8);  start_key = 1'b1;
    at_neg(21); stop_key  = 1'b1;
    at_neg(42); start_key = 1'b0; stop_key = 1'b0;

    // R2 with delay 10, R7 early press held through the lit phase
    lit = 59;
    push(58, 1'b0, 0, "R2 sw=10 still dark");
    push(59, 1'b1, 0, "R2 sw=10 lit");
    push(67, 1'b1, ms_at(67, lit), "R7 early press ignored");
    push(73, 1'b1, ms_at(73, lit), "R7 held key does not stop");
    push(76, 1'b1, ms_at(76, lit), "R6 second press pending");
    push(77, 1'b0, ms_at(76, lit), "R6 second press stops");
    push(90, 1'b0, ms_at(76, lit), "R6 frozen after second press");
    at_neg(46); delay_sw = 8'd10; start_key = 1'b1;
    at_neg(50); stop_key = 1'b1;
    at_neg(70); stop_key = 1'b0;
    at_neg(74); stop_key = 1'b1;
    at_neg(92); start_key = 1'b0; stop_key = 1'b0;
    push(93, 1'b0, 0, "R10 clear after stop");

    // R4 carries and R5 saturation
    lit = 103;
    push(102, 1'b0, 0, "R2 sw=5 still dark");
    push(103, 1'b1, 0, "R2 sw=5 lit");
    push(lit + 36,    1'b1, 9,    "R4 nine");
    push(lit + 40,    1'b1, 10,   "R4 carry to tens");
    push(lit + 400,   1'b1, 100,  "R4 carry to hundreds");
    push(lit + 4000,  1'b1, 1000, "R4 carry to thousands");
    push(lit + 39995, 1'b1, 9998, "R5 just below limit");
    push(lit + 39996, 1'b1, 9999, "R5 limit reached");
    push(lit + 40000, 1'b1, 9999, "R5 no wrap");
    push(lit + 40100, 1'b1, 9999, "R5 still saturated");
    push(lit + 40111, 1'b0, 0,    "R10 clear from saturation");
    at_neg(95); delay_sw = 8'd5; start_key = 1'b1;
    at_neg(lit + 40110); start_key = 1'b0;

    wait (sb_q.size() == 0);
    at_neg(cyc + 2);
    summary();
  end

endmodule